// File: doc/BRIEF.md
# Bus Opcode Injection Sequencer

This block sits between an 8-bit CPU bus and a cartridge ROM. It substitutes a short synthetic instruction stream for a controller read whose own data path is broken. When the CPU reads the controller register from a program running in the upper half of memory, the block takes over the data bus. For the instruction fetches that follow, it feeds an immediate load whose operand carries the live controller bit, then an absolute jump back to the instruction that follows the original read. While it does this, the cartridge ROM select is held inactive so the ROM never contends with the injected bytes.

A DMA engine can steal cycles from the CPU and make it present the same address several times. For that reason the sequencer never counts bus cycles. It moves to its next byte only when the fetch address steps forward by exactly one. When the address repeats, it returns the same byte again, the way a memory would. The bus is sampled on a fast system clock: the falling edge of the CPU phase-2 signal commits state changes, and every output is registered. The block also produces the controller shift clock and the latch strobe.

Top module: `inj_seq_top`

## Requirements
- R1: During and directly after synchronous reset, data_oe is 0, cart_romsel_n is 1, pad_clk is 1 and pad_strobe is 0. The sequencer is idle, so the next fetch is passed through to the ROM.
- R2: A read of the controller address 0x4016 or 0x4017, taken as the 16-bit address {~cpu_romsel_n, cpu_addr}, starts injection. It does so only if the address of the bus cycle just before that read, the base B, has bit 15 set. The first fetch at B+1 then returns 0xA9.
- R3: The injected bytes at B+1 through B+5 are, in order: 0xA9, V, 0x4C, the low byte of B+1, the high byte of B+1.
- R4: V equals 0x40 OR d, where d is the pad_data level sampled during the controller read.
- R5: The sequencer advances only when the fetch address equals the previous injected address plus one. A repeated address returns the same byte again.
- R6: While injecting, cart_romsel_n stays 1. While idle, it equals cpu_romsel_n when m2 is high and 1 when m2 is low.
- R7: If the base address has bit 15 clear, a controller read does not start injection, and later fetches are not driven.
- R8: data_oe is 1 only while m2 is high, cpu_rw is 1 (read), and an injected byte is due at the current address.
- R9: After the high jump byte, the fetch at B+1 is passed through to the ROM without driving, and the sequencer returns to idle.
- R10: pad_clk is 0 during a read of 0x4016 or 0x4017 while m2 is high, and 1 otherwise.
- R11: A write to 0x4016 sets pad_strobe to bit 0 of the written data. A write to 0x4017 leaves pad_strobe unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than m2 |
| rst | input | 1 | Synchronous active-high reset |
| m2 | input | 1 | CPU phase-2 signal; bus valid while high |
| cpu_addr | input | 15 | CPU address bits 14..0 |
| cpu_romsel_n | input | 1 | CPU ROM select, low for 0x8000-0xFFFF |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_d0 | input | 1 | Bit 0 of CPU write data |
| pad_data | input | 1 | Serial data bit from the controller |
| data_out | output | 8 | Injected byte |
| data_oe | output | 1 | Drive enable for data_out onto the CPU bus |
| cart_romsel_n | output | 1 | ROM select forwarded to the cartridge |
| pad_clk | output | 1 | Controller shift clock, low during a controller read |
| pad_strobe | output | 1 | Controller latch strobe |

## Verification
If the phase register is wrong, the next fetch shows it directly: data_out carries the wrong byte, or data_oe is off at an address where a byte is due. The fault is visible within the same bus cycle after one system-clock register stage. A phase that fails to return to idle leaves cart_romsel_n stuck high at the return fetch to B+1. A wrong base register shows up as wrong jump-target bytes. The bench drives a CPU bus model that repeats each address a random number of times, and checks every injected byte against the value expected at that address.

// File: rtl/inj_pkg.sv
`timescale 1ns/1ps
package inj_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_LDA_IMM = 8'hA9;
  localparam logic [BYTE_W-1:0] OP_JMP_ABS = 8'h4C;
  localparam logic [BYTE_W-1:0] IMM_FILL   = 8'h40;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ARM, PH_LDA, PH_IMM, PH_JOP, PH_JLO, PH_JHI
  } inj_phase_e;

  function automatic inj_phase_e phase_after(inj_phase_e ph);
    case (ph)
      PH_ARM:  phase_after = PH_LDA;
      PH_LDA:  phase_after = PH_IMM;
      PH_IMM:  phase_after = PH_JOP;
      PH_JOP:  phase_after = PH_JLO;
      PH_JLO:  phase_after = PH_JHI;
      default: phase_after = ph;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] byte_of(inj_phase_e ph,
                                                logic [ADDR_W-1:0] ret,
                                                logic bitv);
    case (ph)
      PH_LDA:  byte_of = OP_LDA_IMM;
      PH_IMM:  byte_of = {IMM_FILL[BYTE_W-1:1], bitv};
      PH_JOP:  byte_of = OP_JMP_ABS;
      PH_JLO:  byte_of = ret[BYTE_W-1:0];
      PH_JHI:  byte_of = ret[ADDR_W-1:BYTE_W];
      default: byte_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/inj_bus_sampler.sv
`timescale 1ns/1ps
module inj_bus_sampler
  import inj_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              m2,
  input  logic [ADDR_W-1:0] live_addr,
  input  logic              cpu_rw,
  output logic              m2_fall,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              cap_rw
);
  logic m2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      m2_q     <= 1'b0;
      cap_addr <= '0;
      cap_rw   <= 1'b1;
    end else begin
      m2_q <= m2;
      if (m2) begin
        cap_addr <= live_addr;
        cap_rw   <= cpu_rw;
      end
    end
  end

  assign m2_fall = m2_q && !m2;
endmodule

// File: rtl/inj_pad_port.sv
`timescale 1ns/1ps
module inj_pad_port
  import inj_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PAD_ADDR = 16'h4016
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m2,
  input  logic [ADDR_W-1:0] live_addr,
  input  logic              cpu_rw,
  input  logic              cpu_d0,
  input  logic              pad_data,
  output logic              pad_clk,
  output logic              pad_strobe,
  output logic              pad_bit
);
  logic pad_hit, pad_rd, pad_wr;

  assign pad_hit = ({live_addr[ADDR_W-1:1], 1'b0} == PAD_ADDR);
  assign pad_rd  = m2 && cpu_rw && pad_hit;
  assign pad_wr  = m2 && !cpu_rw && (live_addr == PAD_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_clk    <= 1'b1;
      pad_strobe <= 1'b0;
      pad_bit    <= 1'b0;
    end else begin
      pad_clk <= !pad_rd;
      if (pad_wr) pad_strobe <= cpu_d0;
      if (pad_rd) pad_bit    <= pad_data;
    end
  end
endmodule

// File: rtl/inj_seq_core.sv
`timescale 1ns/1ps
module inj_seq_core
  import inj_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PAD_ADDR = 16'h4016
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m2_fall,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              cap_rw,
  input  logic [ADDR_W-1:0] live_addr,
  input  logic              pad_bit,
  output logic              drive_req,
  output logic [BYTE_W-1:0] drive_byte,
  output logic              pass_thru
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  inj_phase_e        phase_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] prev_q;
  logic [ADDR_W-1:0] ret_addr;
  logic              step_hit, hold_hit, cap_is_pad;

  assign ret_addr   = base_q + ONE;
  assign step_hit   = (live_addr == prev_q + ONE);
  assign hold_hit   = (live_addr == prev_q);
  assign cap_is_pad = ({cap_addr[ADDR_W-1:1], 1'b0} == PAD_ADDR);

  always_comb begin
    drive_req  = 1'b0;
    pass_thru  = 1'b0;
    drive_byte = byte_of(phase_q, ret_addr, pad_bit);
    if (phase_q == PH_IDLE) begin
      pass_thru = 1'b1;
    end else if (phase_q == PH_JHI) begin
      if (live_addr == ret_addr) pass_thru = 1'b1;
      else if (hold_hit)         drive_req = 1'b1;
    end else if (step_hit) begin
      drive_req  = 1'b1;
      drive_byte = byte_of(phase_after(phase_q), ret_addr, pad_bit);
    end else if (hold_hit && phase_q != PH_ARM) begin
      drive_req = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      base_q  <= '0;
      prev_q  <= '0;
    end else if (m2_fall) begin
      case (phase_q)
        PH_IDLE: begin
          if (cap_rw && cap_is_pad && base_q[ADDR_W-1]) begin
            phase_q <= PH_ARM;
            prev_q  <= base_q;
          end else begin
            base_q <= cap_addr;
          end
        end
        PH_JHI: begin
          if (cap_rw && cap_addr == ret_addr) begin
            phase_q <= PH_IDLE;
            base_q  <= cap_addr;
          end
        end
        default: begin
          if (cap_rw && cap_addr == prev_q + ONE) begin
            phase_q <= phase_after(phase_q);
            prev_q  <= cap_addr;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/inj_seq_top.sv
`timescale 1ns/1ps
module inj_seq_top
  import inj_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PAD_ADDR = 16'h4016
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m2,
  input  logic [ADDR_W-2:0] cpu_addr,
  input  logic              cpu_romsel_n,
  input  logic              cpu_rw,
  input  logic              cpu_d0,
  input  logic              pad_data,
  output logic [BYTE_W-1:0] data_out,
  output logic              data_oe,
  output logic              cart_romsel_n,
  output logic              pad_clk,
  output logic              pad_strobe
);
  logic [ADDR_W-1:0] live_addr, cap_addr;
  logic              m2_fall, cap_rw, pad_bit;
  logic              drive_req, pass_thru;
  logic [BYTE_W-1:0] drive_byte;

  assign live_addr = {~cpu_romsel_n, cpu_addr};

  inj_bus_sampler u_samp (
    .clk(clk), .rst(rst), .m2(m2), .live_addr(live_addr), .cpu_rw(cpu_rw),
    .m2_fall(m2_fall), .cap_addr(cap_addr), .cap_rw(cap_rw)
  );

  inj_pad_port #(.PAD_ADDR(PAD_ADDR)) u_pad (
    .clk(clk), .rst(rst), .m2(m2), .live_addr(live_addr), .cpu_rw(cpu_rw),
    .cpu_d0(cpu_d0), .pad_data(pad_data), .pad_clk(pad_clk),
    .pad_strobe(pad_strobe), .pad_bit(pad_bit)
  );

  inj_seq_core #(.PAD_ADDR(PAD_ADDR)) u_core (
    .clk(clk), .rst(rst), .m2_fall(m2_fall), .cap_addr(cap_addr),
    .cap_rw(cap_rw), .live_addr(live_addr), .pad_bit(pad_bit),
    .drive_req(drive_req), .drive_byte(drive_byte), .pass_thru(pass_thru)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe       <= 1'b0;
      data_out      <= '0;
      cart_romsel_n <= 1'b1;
    end else begin
      data_oe       <= drive_req && m2 && cpu_rw;
      data_out      <= drive_byte;
      cart_romsel_n <= (pass_thru && m2) ? cpu_romsel_n : 1'b1;
    end
  end
endmodule

// File: rtl/inj_seq_chk.sv
`timescale 1ns/1ps
module inj_seq_chk (
  input logic clk,
  input logic rst,
  input logic m2,
  input logic cpu_rw,
  input logic cpu_romsel_n,
  input logic cpu_d0,
  input logic data_oe,
  input logic cart_romsel_n,
  input logic pad_clk,
  input logic pad_strobe
);
  // R8
  drive_window_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> ($past(m2) && $past(cpu_rw)));

  // R6
  romsel_m2_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(m2) |-> cart_romsel_n);

  // R6
  romsel_vs_drive_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> cart_romsel_n);

  // R10
  padclk_read_chk: assert property (@(posedge clk) disable iff (rst)
    !pad_clk |-> ($past(m2) && $past(cpu_rw) && $past(cpu_romsel_n)));

  // R11
  strobe_write_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pad_strobe) |-> ($past(m2) && !$past(cpu_rw) && pad_strobe == $past(cpu_d0)));

  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!data_oe && cart_romsel_n && pad_clk && !pad_strobe));
endmodule

bind inj_seq_top inj_seq_chk u_chk (
  .clk(clk), .rst(rst), .m2(m2), .cpu_rw(cpu_rw), .cpu_romsel_n(cpu_romsel_n),
  .cpu_d0(cpu_d0), .data_oe(data_oe), .cart_romsel_n(cart_romsel_n),
  .pad_clk(pad_clk), .pad_strobe(pad_strobe)
);

// File: tb/sim_inj_seq_top.sv
`timescale 1ns/1ps
module sim_inj_seq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m2 = 1'b0;
  logic [14:0] cpu_addr = '0;
  logic        cpu_romsel_n = 1'b1;
  logic        cpu_rw = 1'b1;
  logic        cpu_d0 = 1'b0;
  logic        pad_data = 1'b0;
  logic [7:0]  data_out;
  logic        data_oe, cart_romsel_n, pad_clk, pad_strobe;

  logic [7:0] s_data;
  logic       s_oe, s_rom, s_pclk, s_strobe;
  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  inj_seq_top u0 (
    .clk(clk), .rst(rst), .m2(m2), .cpu_addr(cpu_addr),
    .cpu_romsel_n(cpu_romsel_n), .cpu_rw(cpu_rw), .cpu_d0(cpu_d0),
    .pad_data(pad_data), .data_out(data_out), .data_oe(data_oe),
    .cart_romsel_n(cart_romsel_n), .pad_clk(pad_clk), .pad_strobe(pad_strobe)
  );

  // {addr16, rw, pad, exp_oe, exp_data8, exp_rom, exp_pclk}; base 0xC123, d=1
  localparam logic [28:0] VEC [15] = '{
    {16'hC121, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},
    {16'hC122, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},
    {16'hC123, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},
    {16'h4016, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0},
    {16'h4016, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0},
    {16'hC124, 1'b1, 1'b0, 1'b1, 8'hA9, 1'b1, 1'b1},
    {16'hC124, 1'b1, 1'b0, 1'b1, 8'hA9, 1'b1, 1'b1},
    {16'hC125, 1'b1, 1'b0, 1'b1, 8'h41, 1'b1, 1'b1},
    {16'hC126, 1'b1, 1'b0, 1'b1, 8'h4C, 1'b1, 1'b1},
    {16'hC126, 1'b1, 1'b0, 1'b1, 8'h4C, 1'b1, 1'b1},
    {16'hC127, 1'b1, 1'b0, 1'b1, 8'h24, 1'b1, 1'b1},
    {16'hC128, 1'b1, 1'b0, 1'b1, 8'hC1, 1'b1, 1'b1},
    {16'hC128, 1'b1, 1'b0, 1'b1, 8'hC1, 1'b1, 1'b1},
    {16'hC124, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    {16'hC125, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1}
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(logic [15:0] a, logic rw, logic d0);
    @(negedge clk);
    cpu_addr = a[14:0]; cpu_romsel_n = ~a[15]; cpu_rw = rw; cpu_d0 = d0;
    repeat (2) @(negedge clk);
    m2 = 1'b1;
    repeat (3) @(negedge clk);
    s_oe = data_oe; s_data = data_out; s_rom = cart_romsel_n;
    s_pclk = pad_clk; s_strobe = pad_strobe;
    m2 = 1'b0;
    @(negedge clk);
  endtask

  task automatic fetch_chk(logic [15:0] a, logic eoe, logic [7:0] edata, logic erom, string req);
    bus_cycle(a, 1'b1, 1'b0);
    chk({req, " oe"}, 16'(s_oe), 16'(eoe));
    if (eoe) chk({req, " byte"}, 16'(s_data), 16'(edata));
    chk({req, " romsel"}, 16'(s_rom), 16'(erom));
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] b;
    logic [15:0] r;
    logic        d;
    logic [7:0]  eb [5];
    int          rep;

    repeat (5) @(negedge clk);
    chk("R1 reset oe", 16'(data_oe), 16'd0);
    chk("R1 reset romsel", 16'(cart_romsel_n), 16'd1);
    chk("R1 reset pclk", 16'(pad_clk), 16'd1);
    chk("R1 reset strobe", 16'(pad_strobe), 16'd0);
    rst = 1'b0;

    // table walk: R2 R3 R4 R5 R6 R9 R10
    for (int i = 0; i < 15; i++) begin
      pad_data = VEC[i][11];
      bus_cycle(VEC[i][28:13], VEC[i][12], 1'b0);
      chk($sformatf("R8 vec%0d oe", i), 16'(s_oe), 16'(VEC[i][10]));
      if (VEC[i][10]) chk($sformatf("R3 R5 vec%0d byte", i), 16'(s_data), 16'(VEC[i][9:2]));
      chk($sformatf("R6 R9 vec%0d romsel", i), 16'(s_rom), 16'(VEC[i][1]));
      chk($sformatf("R10 vec%0d pclk", i), 16'(s_pclk), 16'(VEC[i][0]));
    end

    // R6: ROM select held inactive while m2 is low
    @(negedge clk);
    cpu_addr = 15'h0000; cpu_romsel_n = 1'b0; cpu_rw = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 m2 low romsel", 16'(cart_romsel_n), 16'd1);
    chk("R8 m2 low oe", 16'(data_oe), 16'd0);

    // R7: base below 0x8000 does not arm
    fetch_chk(16'h6100, 1'b0, 8'h00, 1'b1, "R7 ram");
    fetch_chk(16'h6102, 1'b0, 8'h00, 1'b1, "R7 ram");
    fetch_chk(16'h4016, 1'b0, 8'h00, 1'b1, "R7 read");
    fetch_chk(16'h6103, 1'b0, 8'h00, 1'b1, "R7 next");
    fetch_chk(16'h8000, 1'b0, 8'h00, 1'b0, "R7 idle");

    // R2 R4: 0x4017 also arms, d = 0
    pad_data = 1'b0;
    fetch_chk(16'hD000, 1'b0, 8'h00, 1'b0, "R2 base");
    bus_cycle(16'h4017, 1'b1, 1'b0);
    chk("R10 4017 pclk", 16'(s_pclk), 16'd0);
    pad_data = 1'b1;
    fetch_chk(16'hD001, 1'b1, 8'hA9, 1'b1, "R2 4017");
    fetch_chk(16'hD002, 1'b1, 8'h40, 1'b1, "R4 d0");

    // R1: reset in the middle of injection
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 midrst oe", 16'(data_oe), 16'd0);
    chk("R1 midrst romsel", 16'(cart_romsel_n), 16'd1);
    rst = 1'b0;
    fetch_chk(16'hD003, 1'b0, 8'h00, 1'b0, "R1 idle after reset");

    // R11: strobe writes
    bus_cycle(16'h4016, 1'b0, 1'b1);
    chk("R11 strobe set", 16'(s_strobe), 16'd1);
    bus_cycle(16'h4017, 1'b0, 1'b0);
    chk("R11 4017 ignored", 16'(s_strobe), 16'd1);
    bus_cycle(16'h4016, 1'b0, 1'b0);
    chk("R11 strobe clear", 16'(s_strobe), 16'd0);

    // R5 R3 R4: CPU model with random address repeats
    for (int n = 0; n < 24; n++) begin
      b = 16'h8010 + 16'($urandom_range(0, 16'h7FD0));
      r = b + 16'd1;
      d = 1'($urandom % 2);
      eb[0] = 8'hA9; eb[1] = {7'b0100000, d}; eb[2] = 8'h4C;
      eb[3] = r[7:0]; eb[4] = r[15:8];
      pad_data = d;
      for (int k = 2; k >= 0; k--) begin
        rep = 1 + int'($urandom % 3);
        for (int j = 0; j < rep; j++) fetch_chk(b - 16'(k), 1'b0, 8'h00, 1'b0, "R9 idle fetch");
      end
      rep = 1 + int'($urandom % 3);
      for (int j = 0; j < rep; j++) fetch_chk(16'h4016, 1'b0, 8'h00, 1'b1, "R2 pad read");
      pad_data = ~d;
      for (int k = 0; k < 5; k++) begin
        rep = 1 + int'($urandom % 3);
        for (int j = 0; j < rep; j++) fetch_chk(b + 16'(k + 1), 1'b1, eb[k], 1'b1, "R5 R3 R4 stream");
      end
      fetch_chk(r, 1'b0, 8'h00, 1'b0, "R9 return");
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule